// File: doc/BRIEF.md
# First-Level Address Translation Buffer with Conditional Flush

This block caches recent virtual-to-physical page translations for a 48-bit virtual and 40-bit physical address space. It keeps two separate, fully associative arrays: thirty-two slots for 4 KB pages and eight slots for 2 MB pages. A lookup address is compared against every valid slot of both arrays in the same cycle. The block returns a hit flag, the translated physical address and the size of the page that matched. New translations enter through a fill port, which carries a virtual page number, a physical page number and a size select.

Loading a new page-table root normally forces the whole buffer to be discarded. Here a sticky modification flag decides instead. Logic around the block pulses a strobe whenever page-table memory is written. A later root load empties both arrays only when that flag is set, and the load then clears the flag. Root loads with no page-table edit since the last flush leave every cached translation in place. The parameter `FILTER_EN` selects this filtered behaviour (1, default) or the plain variant in which every root load empties the buffer (0).

Top module: `fa_tlb`

## Requirements
- R1: During and immediately after reset every slot is invalid; whenever there is no hit, `hit`=0, `pa`=0 and `pg_large`=0.
- R2: A lookup whose `lk_va[47:12]` equals the tag of a valid 4 KB slot gives `hit`=1, `pg_large`=0 and `pa` = {slot frame (28 bits), `lk_va[11:0]`}.
- R3: A large fill takes its tag from `fill_vpn[35:9]` and its frame from `fill_ppn[27:9]`. The low nine bits of both are ignored. A lookup whose `lk_va[47:21]` equals a valid large tag gives `hit`=1, `pg_large`=1 and `pa` = {frame (19 bits), `lk_va[20:0]`}.
- R4: When a 4 KB slot and a large slot both match, the 4 KB translation is returned.
- R5: The 4 KB array holds 32 translations and the large array holds 8. Fills into one array never evict the other.
- R6: A fill chooses its slot in this order: first the valid slot whose tag equals the fill tag, which it overwrites; otherwise the lowest-numbered invalid slot; otherwise the slot under a per-array round-robin pointer. The pointer is 0 after reset and advances by one, wrapping, only on fills that use it.
- R7: A filled translation is visible to lookups from the cycle after the fill. A lookup in the fill cycle does not see it.
- R8: A `pt_mod` pulse sets a sticky modification flag. A `base_wr` while the flag is clear leaves every slot intact.
- R9: A `base_wr` while the flag is set invalidates both arrays from the next cycle and clears the flag. A `pt_mod` in that same cycle leaves the flag set for later.
- R10: A lookup in the same cycle as an invalidating `base_wr` returns the result from before the flush.
- R11: A fill presented in the same cycle as an invalidating `base_wr` is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_va | input | 48 | Lookup virtual address |
| fill_en | input | 1 | Write one translation this cycle |
| fill_vpn | input | 36 | Fill virtual page number (VA[47:12]) |
| fill_ppn | input | 28 | Fill physical page number (PA[39:12]) |
| fill_large | input | 1 | 1 = fill targets the 2 MB array |
| base_wr | input | 1 | Page-table root register written |
| pt_mod | input | 1 | A paging structure was modified |
| hit | output | 1 | Lookup matched a valid slot |
| pa | output | 40 | Translated physical address, 0 on miss |
| pg_large | output | 1 | 1 = hit came from the 2 MB array |

## Verification
A lost or wrongly set modification flag shows up at the first later root load. The next lookup either still hits when it should miss, or misses a translation that should have survived. A replacement pointer that drifts evicts the wrong page. This becomes visible only once an array is full and one more fill arrives, so the bench fills each array past capacity and probes both the evicted page and its neighbours. Frame bits stored in the wrong slot, or the two arrays selected in the wrong priority, corrupt `pa` on the very lookup that hits the slot, so each hit is compared bit for bit.

// File: rtl/fa_tlb_pkg.sv
package fa_tlb_pkg;

   typedef enum logic {
      PG_SMALL = 1'b0,
      PG_LARGE = 1'b1
   } pg_size_e;

endpackage

// File: rtl/fa_tlb_victim.sv
// Slot selection for one array: same-tag overwrite, then lowest free slot,
// then a round-robin pointer that moves only when it was consumed.
module fa_tlb_victim #(
   parameter int N  = 32,
   localparam int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  valid,
   input  logic [N-1:0]  same_tag,
   input  logic          wr_en,
   output logic [IW-1:0] idx
);

   logic [IW-1:0] rr_q;
   logic [IW-1:0] match_idx;
   logic [IW-1:0] free_idx;
   logic          any_match;
   logic          any_free;

   always_comb begin
      match_idx = '0;
      free_idx  = '0;
      any_match = 1'b0;
      any_free  = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (same_tag[i]) begin
            match_idx = IW'(i);
            any_match = 1'b1;
         end
         if (!valid[i]) begin
            free_idx = IW'(i);
            any_free = 1'b1;
         end
      end
   end

   always_comb begin
      if (any_match)     idx = match_idx;
      else if (any_free) idx = free_idx;
      else               idx = rr_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rr_q <= '0;
      end else if (wr_en && !any_match && !any_free) begin
         if (rr_q == IW'(N - 1)) rr_q <= '0;
         else                    rr_q <= rr_q + 1'b1;
      end
   end

endmodule

// File: rtl/fa_tlb_array.sv
// One fully associative translation array with parallel tag compare.
module fa_tlb_array #(
   parameter int N     = 32,
   parameter int TAG_W = 36,
   parameter int DAT_W = 28,
   localparam int IW   = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_en,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [DAT_W-1:0] wr_dat,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             lk_hit,
   output logic [DAT_W-1:0] lk_dat
);

   logic [N-1:0]     valid_q;
   logic [TAG_W-1:0] tag_q [N];
   logic [DAT_W-1:0] dat_q [N];
   logic [N-1:0]     hit_vec;
   logic [N-1:0]     same_vec;
   logic [IW-1:0]    wr_idx;

   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign hit_vec[g]  = valid_q[g] && (tag_q[g] == lk_tag);
      assign same_vec[g] = valid_q[g] && (tag_q[g] == wr_tag);
   end

   always_comb begin
      lk_dat = '0;
      for (int i = 0; i < N; i++) begin
         if (hit_vec[i]) lk_dat = lk_dat | dat_q[i];
      end
   end

   assign lk_hit = |hit_vec;

   fa_tlb_victim #(.N(N)) u_victim (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid    (valid_q),
      .same_tag (same_vec),
      .wr_en    (wr_en),
      .idx      (wr_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !flush) begin
         tag_q[wr_idx] <= wr_tag;
         dat_q[wr_idx] <= wr_dat;
      end
   end

endmodule

// File: rtl/fa_tlb_flush_filter.sv
// Decides whether a root load must empty the arrays.
module fa_tlb_flush_filter #(
   parameter bit FILTER_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic base_wr,
   input  logic pt_mod,
   output logic flush
);

   if (FILTER_EN) begin : g_filtered
      logic dirty_q;
      always_ff @(posedge clk) begin
         if (!rst_n) dirty_q <= 1'b0;
         else        dirty_q <= pt_mod | (dirty_q & ~base_wr);
      end
      assign flush = base_wr & dirty_q;
   end else begin : g_plain
      logic unused_mod;
      assign unused_mod = pt_mod & clk & rst_n;
      assign flush      = base_wr;
   end

endmodule

// File: rtl/fa_tlb.sv
module fa_tlb
   import fa_tlb_pkg::*;
#(
   parameter int VA_W      = 48,
   parameter int PA_W      = 40,
   parameter int SMALL_N   = 32,
   parameter int LARGE_N   = 8,
   parameter int SMALL_SH  = 12,
   parameter int LARGE_SH  = 21,
   parameter bit FILTER_EN = 1'b1,
   localparam int VPN_W    = VA_W - SMALL_SH,
   localparam int PPN_W    = PA_W - SMALL_SH,
   localparam int LTAG_W   = VA_W - LARGE_SH,
   localparam int LFRM_W   = PA_W - LARGE_SH,
   localparam int LDIFF    = LARGE_SH - SMALL_SH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VA_W-1:0]  lk_va,
   input  logic             fill_en,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn,
   input  logic             fill_large,
   input  logic             base_wr,
   input  logic             pt_mod,
   output logic             hit,
   output logic [PA_W-1:0]  pa,
   output logic             pg_large
);

   if (LARGE_SH <= SMALL_SH) begin : g_bad_shift
      $error("fa_tlb: LARGE_SH must exceed SMALL_SH");
   end
   if (SMALL_N < 2 || LARGE_N < 2) begin : g_bad_depth
      $error("fa_tlb: each array needs at least two slots");
   end
   if (PA_W <= LARGE_SH || VA_W <= LARGE_SH) begin : g_bad_width
      $error("fa_tlb: address widths must exceed the large page shift");
   end

   logic              flush_w;
   logic              s_hit;
   logic              l_hit;
   logic [PPN_W-1:0]  s_dat;
   logic [LFRM_W-1:0] l_dat;
   logic              s_wr;
   logic              l_wr;
   pg_size_e          sel_size;

   assign sel_size = fill_large ? PG_LARGE : PG_SMALL;
   assign s_wr     = fill_en && (sel_size == PG_SMALL) && !flush_w;
   assign l_wr     = fill_en && (sel_size == PG_LARGE) && !flush_w;

   fa_tlb_flush_filter #(.FILTER_EN(FILTER_EN)) u_filter (
      .clk     (clk),
      .rst_n   (rst_n),
      .base_wr (base_wr),
      .pt_mod  (pt_mod),
      .flush   (flush_w)
   );

   fa_tlb_array #(.N(SMALL_N), .TAG_W(VPN_W), .DAT_W(PPN_W)) u_small (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (flush_w),
      .wr_en  (s_wr),
      .wr_tag (fill_vpn),
      .wr_dat (fill_ppn),
      .lk_tag (lk_va[VA_W-1:SMALL_SH]),
      .lk_hit (s_hit),
      .lk_dat (s_dat)
   );

   fa_tlb_array #(.N(LARGE_N), .TAG_W(LTAG_W), .DAT_W(LFRM_W)) u_large (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (flush_w),
      .wr_en  (l_wr),
      .wr_tag (fill_vpn[VPN_W-1:LDIFF]),
      .wr_dat (fill_ppn[PPN_W-1:LDIFF]),
      .lk_tag (lk_va[VA_W-1:LARGE_SH]),
      .lk_hit (l_hit),
      .lk_dat (l_dat)
   );

   always_comb begin
      hit      = 1'b0;
      pa       = '0;
      pg_large = 1'b0;
      if (s_hit) begin
         hit = 1'b1;
         pa  = {s_dat, lk_va[SMALL_SH-1:0]};
      end else if (l_hit) begin
         hit      = 1'b1;
         pa       = {l_dat, lk_va[LARGE_SH-1:0]};
         pg_large = 1'b1;
      end
   end

endmodule

// File: rtl/fa_tlb_chk.sv
module fa_tlb_chk #(
   parameter int VA_W      = 48,
   parameter int PA_W      = 40,
   parameter int SMALL_SH  = 12,
   parameter int LARGE_SH  = 21,
   parameter bit FILTER_EN = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic [VA_W-1:0] lk_va,
   input logic            fill_en,
   input logic            base_wr,
   input logic            pt_mod,
   input logic            flush,
   input logic            hit,
   input logic [PA_W-1:0] pa,
   input logic            pg_large
);

   logic sh_dirty;
   always_ff @(posedge clk) begin
      if (!rst_n) sh_dirty <= 1'b0;
      else        sh_dirty <= pt_mod | (sh_dirty & ~base_wr);
   end

   // R1
   a_r1_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (pa == '0 && !pg_large));

   // R2
   a_r2_small_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !pg_large) |-> pa[SMALL_SH-1:0] == lk_va[SMALL_SH-1:0]);

   // R3
   a_r3_large_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && pg_large) |-> pa[LARGE_SH-1:0] == lk_va[LARGE_SH-1:0]);

   // R8
   a_r8_clean_base_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (FILTER_EN && base_wr && !sh_dirty && !fill_en) |=>
         (lk_va != $past(lk_va)) || (hit == $past(hit) && pa == $past(pa)));

   // R9
   a_r9_flush_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (!FILTER_EN || sh_dirty));

   // R9, R11
   a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !hit);

endmodule

bind fa_tlb fa_tlb_chk #(
   .VA_W(VA_W), .PA_W(PA_W), .SMALL_SH(SMALL_SH),
   .LARGE_SH(LARGE_SH), .FILTER_EN(FILTER_EN)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .lk_va    (lk_va),
   .fill_en  (fill_en),
   .base_wr  (base_wr),
   .pt_mod   (pt_mod),
   .flush    (flush_w),
   .hit      (hit),
   .pa       (pa),
   .pg_large (pg_large)
);

// File: tb/fa_tlb_tb_top.sv
`timescale 1ns/1ps
module fa_tlb_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [47:0] lk_va;
   logic        fill_en;
   logic [35:0] fill_vpn;
   logic [27:0] fill_ppn;
   logic        fill_large;
   logic        base_wr;
   logic        pt_mod;
   logic        hit;
   logic [39:0] pa;
   logic        pg_large;

   int checks   = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   fa_tlb dut_i (
      .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .fill_en(fill_en),
      .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_large(fill_large),
      .base_wr(base_wr), .pt_mod(pt_mod), .hit(hit), .pa(pa),
      .pg_large(pg_large)
   );

   // Reference state built from the requirements
   bit          sv [32];
   logic [35:0] st [32];
   logic [27:0] sp [32];
   int          srr;
   bit          lv [8];
   logic [26:0] lt [8];
   logic [18:0] lp [8];
   int          lrr;
   bit          mdirty;

   function automatic void exp_lookup(input logic [47:0] va, output bit h,
                                      output logic [39:0] p, output bit lg);
      h = 0; p = '0; lg = 0;
      for (int i = 0; i < 8; i++)
         if (lv[i] && lt[i] == va[47:21]) begin h = 1; lg = 1; p = {lp[i], va[20:0]}; end
      for (int i = 0; i < 32; i++)
         if (sv[i] && st[i] == va[47:12]) begin h = 1; lg = 0; p = {sp[i], va[11:0]}; end
   endfunction

   task automatic model_clock();
      bit fl;
      int k;
      if (!rst_n) begin
         foreach (sv[i]) sv[i] = 0;
         foreach (lv[i]) lv[i] = 0;
         srr = 0; lrr = 0; mdirty = 0;
         return;
      end
      fl = base_wr && mdirty;
      if (fl) begin
         foreach (sv[i]) sv[i] = 0;
         foreach (lv[i]) lv[i] = 0;
      end else if (fill_en && !fill_large) begin
         k = -1;
         for (int i = 0; i < 32; i++) if (k < 0 && sv[i] && st[i] == fill_vpn) k = i;
         for (int i = 0; i < 32; i++) if (k < 0 && !sv[i]) k = i;
         if (k < 0) begin k = srr; srr = (srr + 1) % 32; end
         sv[k] = 1; st[k] = fill_vpn; sp[k] = fill_ppn;
      end else if (fill_en && fill_large) begin
         k = -1;
         for (int i = 0; i < 8; i++) if (k < 0 && lv[i] && lt[i] == fill_vpn[35:9]) k = i;
         for (int i = 0; i < 8; i++) if (k < 0 && !lv[i]) k = i;
         if (k < 0) begin k = lrr; lrr = (lrr + 1) % 8; end
         lv[k] = 1; lt[k] = fill_vpn[35:9]; lp[k] = fill_ppn[27:9];
      end
      mdirty = pt_mod || (mdirty && !base_wr);
   endtask

   task automatic cyc(input string tag);
      bit eh, el;
      logic [39:0] ep;
      #1;
      exp_lookup(lk_va, eh, ep, el);
      checks++;
      if (hit !== eh || pa !== ep || pg_large !== el) begin
         failures++;
         $display("FAIL %s: actual hit=%0b pa=%h large=%0b expected hit=%0b pa=%h large=%0b",
                  tag, hit, pa, pg_large, eh, ep, el);
      end
      @(posedge clk);
      model_clock();
      @(negedge clk);
   endtask

   task automatic idle();
      fill_en = 0; fill_large = 0; fill_vpn = '0; fill_ppn = '0;
      base_wr = 0; pt_mod = 0;
   endtask

   task automatic lit(input string tag, input bit eh, input logic [39:0] ep, input bit el);
      #1;
      checks++;
      if (hit !== eh || pa !== ep || pg_large !== el) begin
         failures++;
         $display("FAIL %s: actual hit=%0b pa=%h large=%0b expected hit=%0b pa=%h large=%0b",
                  tag, hit, pa, pg_large, eh, ep, el);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   localparam logic [35:0] VA_A = 36'h123456789;
   localparam logic [35:0] VB   = 36'h0ABCDE000;

   initial begin
      void'($urandom(32'd7));
      rst_n = 0; idle(); lk_va = {VA_A, 12'h345};
      @(negedge clk);
      cyc("R1 reset");
      cyc("R1 reset");
      rst_n = 1;
      cyc("R1 after reset");

      // R7 / R2: fill then lookup
      fill_en = 1; fill_vpn = VA_A; fill_ppn = 28'hABCDE01;
      cyc("R7 fill-cycle miss");
      idle();
      lit("R2 literal", 1'b1, {28'hABCDE01, 12'h345}, 1'b0);
      cyc("R2 small hit");

      // R3: large fill with junk low bits
      fill_en = 1; fill_large = 1; fill_vpn = VB | 36'h1FF; fill_ppn = 28'h7654321;
      lk_va = {VB, 12'h000} | 48'h1ABCDE;
      cyc("R3 fill cycle");
      idle();
      lit("R3 literal", 1'b1, {28'h7654321 >> 9, 21'h1ABCDE}, 1'b1);
      cyc("R3 large hit");

      // R4: overlapping small wins
      fill_en = 1; fill_vpn = VB | 36'h5; fill_ppn = 28'h0000F0F;
      cyc("R4 fill");
      idle(); lk_va = {VB | 36'h5, 12'hABC};
      cyc("R4 small wins");
      lk_va = {VB | 36'h6, 12'hABC};
      cyc("R4 other page large");

      // R8: root load with clean flag keeps entries
      base_wr = 1; lk_va = {VA_A, 12'h001};
      cyc("R8 clean base");
      idle();
      cyc("R8 entry kept");

      // R9 / R10 / R11
      pt_mod = 1;
      cyc("R9 mark");
      idle(); base_wr = 1; fill_en = 1; fill_vpn = 36'h42; fill_ppn = 28'h99;
      cyc("R10 pre-flush hit");
      idle();
      cyc("R9 flushed");
      lk_va = {36'h42, 12'h0};
      cyc("R11 fill dropped");
      lk_va = {VB, 12'h0} | 48'h12345;
      cyc("R9 large flushed");
      fill_en = 1; fill_vpn = VA_A; fill_ppn = 28'h1;
      cyc("R9 refill");
      idle(); base_wr = 1; lk_va = {VA_A, 12'h0};
      cyc("R9 flag cleared");
      idle();
      cyc("R9 no second flush");

      // R9: pt_mod with base_wr keeps flag
      pt_mod = 1;
      cyc("R9 mark2");
      idle(); base_wr = 1; pt_mod = 1;
      cyc("R9 flush+mark");
      idle(); base_wr = 1;
      cyc("R9 flag survived");
      idle();
      cyc("R9 second flush");

      // R5 / R6 capacity and replacement
      for (int i = 0; i < 32; i++) begin
         fill_en = 1; fill_vpn = 36'h100 + 36'(i); fill_ppn = 28'h2000 + 28'(i);
         cyc("R5 small fill");
      end
      for (int i = 0; i < 8; i++) begin
         fill_en = 1; fill_large = 1; fill_vpn = 36'h800000 + 36'(i << 9);
         fill_ppn = 28'h300000 + 28'(i << 9);
         cyc("R5 large fill");
      end
      idle();
      for (int i = 0; i < 32; i++) begin
         lk_va = {36'h100 + 36'(i), 12'h7};
         cyc("R5 small kept");
      end
      for (int i = 0; i < 8; i++) begin
         lk_va = {36'h800000 + 36'(i << 9), 12'h7};
         cyc("R5 large kept");
      end
      fill_en = 1; fill_vpn = 36'h999; fill_ppn = 28'h999;
      cyc("R6 evict fill");
      idle(); lk_va = {36'h100, 12'h0};
      lit("R6 slot0 evicted", 1'b0, 40'h0, 1'b0);
      cyc("R6 slot0 evicted");
      lk_va = {36'h101, 12'h0};
      cyc("R6 slot1 kept");
      fill_en = 1; fill_vpn = 36'h105; fill_ppn = 28'hBEEF;
      cyc("R6 overwrite fill");
      idle(); lk_va = {36'h105, 12'h10};
      cyc("R6 overwritten");
      fill_en = 1; fill_vpn = 36'h998; fill_ppn = 28'h998;
      cyc("R6 evict fill 2");
      idle(); lk_va = {36'h101, 12'h0};
      cyc("R6 slot1 evicted");
      lk_va = {36'h102, 12'h0};
      cyc("R6 slot2 kept");

      // Random mix
      for (int n = 0; n < 4000; n++) begin
         idle();
         fill_en    = ($urandom % 10) < 3;
         fill_large = ($urandom % 4) == 0;
         fill_vpn   = {27'h5500 + 27'($urandom % 12), 9'($urandom % 24)};
         fill_ppn   = 28'($urandom);
         base_wr    = ($urandom % 20) == 0;
         pt_mod     = ($urandom % 20) == 0;
         lk_va      = {27'h5500 + 27'($urandom % 12), 9'($urandom % 24), 12'($urandom)};
         cyc("R2 R3 R4 R6 R9 random");
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule